// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers a parameterized set of interrupt inputs (32 by default) and folds them into one active-low request line for a processor. Each input has a software-written vector word and a mode word. The mode word sets a three-bit priority level and chooses between active-low level sensing and falling-edge capture. Software reaches all of this through a word-addressed register port with separate read and write strobes. Read data comes back in the cycle after the read strobe.

The handler reads the acknowledge register. The read returns the vector of the best pending, enabled input and marks that level as being serviced by pushing its priority onto an eight-entry nesting stack. From then on the request line is raised only for a pending input whose priority is strictly above the stack top. A write of any value to the end-of-interrupt register pops one level. When nothing is eligible, an acknowledge read returns a programmable spurious value. Command registers set or clear enable bits and discard captured edges. A one-bit debug control word is stored and has no other effect.

Word addresses (NSRC = 32): mode words 0..31, vector words 32..63, acknowledge 64, spurious value 65, end-of-interrupt 66, enable command 67, disable command 68, edge-clear command 69, enable mask (read-only) 70, debug control 71. Mode word layout: bits [2:0] priority (7 highest), bit 5 trigger (0 = active-low level, 1 = falling edge).

Top module: `vpic`

## Requirements
- R1: After reset the request line is high, every input is disabled and has no captured edge, the nesting stack is empty, and the spurious value is 0, so an acknowledge read returns 0.
- R2: A write to address 67 sets the enable bit of every input whose data bit is 1. A write to address 68 clears those bits. A read of address 70 returns the enable bits. A disabled input never raises the request line.
- R3: An input with trigger bit 0 is pending while enabled and its pin is low. It captures nothing, so releasing the pin withdraws the request.
- R4: An input with trigger bit 1 captures a high-to-low transition of its pin and stays pending after the pin returns high. A write to address 69 discards the captured edge of every input whose data bit is 1.
- R5: The pending input with the largest priority in mode bits [2:0] wins. Among equal priorities the lowest input number wins. A mode word reads back with its priority in bits [2:0] and its trigger in bit 5.
- R6: When an input is eligible, a read of address 64 returns that input's vector word in the following cycle and pushes its priority. If the input is edge-triggered, the read also discards its captured edge.
- R7: With the stack non-empty, the request line is low only while some pending input has a priority strictly greater than the stack top.
- R8: A write of any value to address 66 pops one stack level. A write to address 66 with an empty stack changes nothing.
- R9: The stack holds eight levels. A push onto a full stack is ignored. Eight pops empty a full stack and re-open the request line to any pending input.
- R10: A read of address 64 while no input is eligible returns the value stored at address 65 and pushes nothing. Address 65 reads back what was written.
- R11: Address 71 stores a debug control bit (data bit 0) that reads back and does not alter interrupt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | NSRC | Interrupt input pins, active low, synchronous to clk |
| addr | input | ADDR_W | Word address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (read of address 64 acknowledges) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle and that the pins are already synchronous to the clock. The bench drives every access from a task that raises exactly one strobe for one cycle and changes pins only on the falling clock edge. Nesting is driven one level at a time: a new higher-priority pin is lowered only after the previous acknowledge, so each stack depth is reached through its own legal sequence.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int PRIO_W   = 3;  // priority field width
    localparam int TRIG_BIT = 5;  // trigger bit position in a mode word
    // control register offsets above the two per-input banks
    localparam int OFS_ACK  = 0;
    localparam int OFS_SPUR = 1;
    localparam int OFS_EOI  = 2;
    localparam int OFS_EN   = 3;
    localparam int OFS_DIS  = 4;
    localparam int OFS_CLR  = 5;
    localparam int OFS_MASK = 6;
    localparam int OFS_DBG  = 7;
    localparam int N_CTRL   = 8;
endpackage

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
    parameter int NSRC  = 32,
    parameter int PW    = 3,
    parameter int IDX_W = 5
) (
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0][PW-1:0] prio,
    output logic                    any,
    output logic [IDX_W-1:0]        idx,
    output logic [PW-1:0]           best
);
    // scan from the top down; >= lets a lower index take over an equal level
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && (!any || prio[i] >= best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = prio[i];
            end
        end
    end
endmodule

// File: rtl/vpic_nest_stack.sv
module vpic_nest_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic         empty,
    output logic         full,
    output logic [W-1:0] top
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0]        cnt;
        logic [DEPTH-1:0][W-1:0] mem;
    } stk_t;

    stk_t st_d, st_q;
    logic [IDX_W-1:0] top_idx;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign top_idx = IDX_W'(st_q.cnt - 1'b1);
    assign top     = empty ? '0 : st_q.mem[top_idx];

    always_comb begin
        st_d = st_q;
        if (pop) begin
            if (!empty) st_d.cnt = st_q.cnt - 1'b1;
        end else if (push && !full) begin
            st_d.mem[IDX_W'(st_q.cnt)] = push_val;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_full_push_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> $stable(st_q.cnt));
    p_empty_pop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (st_q.cnt == '0));
    p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    p_push_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (top == $past(push_val)));
endmodule

// File: rtl/vpic.sv
module vpic
    import vpic_pkg::*;
#(
    parameter int NSRC   = 32,  // must not exceed DATA_W
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(2 * NSRC + N_CTRL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);
    localparam int SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int CBASE  = 2 * NSRC;

    typedef struct packed {
        logic [NSRC-1:0]              en;
        logic [NSRC-1:0]              latch;
        logic [NSRC-1:0]              prev;
        logic [NSRC-1:0]              trig;
        logic [NSRC-1:0][PRIO_W-1:0]  prio;
        logic [NSRC-1:0][DATA_W-1:0]  vec;
        logic [DATA_W-1:0]            spur;
        logic [DATA_W-1:0]            rdata;
        logic                         dbg;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0]   pend;
    logic              win_any, eligible, stk_empty, stk_full;
    logic [SIDX_W-1:0] win_idx;
    logic [PRIO_W-1:0] win_prio, stk_top;
    logic              ack, push, pop;

    assign pend = st_q.en & ((st_q.trig & st_q.latch) | (~st_q.trig & ~src_n));

    vpic_arbiter #(.NSRC(NSRC), .PW(PRIO_W), .IDX_W(SIDX_W)) u_arb (
        .pend (pend),
        .prio (st_q.prio),
        .any  (win_any),
        .idx  (win_idx),
        .best (win_prio)
    );

    assign eligible = win_any && (stk_empty || win_prio > stk_top);
    assign ack      = rd_en && (int'(addr) == CBASE + OFS_ACK);
    assign push     = ack && eligible;
    assign pop      = wr_en && (int'(addr) == CBASE + OFS_EOI);
    assign irq_n    = ~eligible;
    assign rdata    = st_q.rdata;

    vpic_nest_stack #(.DEPTH(DEPTH), .W(PRIO_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_val (win_prio),
        .pop      (pop),
        .empty    (stk_empty),
        .full     (stk_full),
        .top      (stk_top)
    );

    always_comb begin
        int a;
        a    = int'(addr);
        st_d = st_q;
        // edge capture first, so commands and acknowledges below win over it
        st_d.latch = st_q.latch | (st_q.prev & ~src_n & st_q.trig);
        st_d.prev  = src_n;
        if (wr_en) begin
            if (a < NSRC) begin
                st_d.prio[a] = wdata[PRIO_W-1:0];
                st_d.trig[a] = wdata[TRIG_BIT];
            end else if (a < CBASE) begin
                st_d.vec[a-NSRC] = wdata;
            end else begin
                case (a - CBASE)
                    OFS_SPUR: st_d.spur  = wdata;
                    OFS_EN:   st_d.en    = st_q.en | wdata[NSRC-1:0];
                    OFS_DIS:  st_d.en    = st_q.en & ~wdata[NSRC-1:0];
                    OFS_CLR:  st_d.latch = st_d.latch & ~wdata[NSRC-1:0];
                    OFS_DBG:  st_d.dbg   = wdata[0];
                    default:  ;
                endcase
            end
        end
        if (push) st_d.latch[win_idx] = 1'b0;
        if (rd_en) begin
            st_d.rdata = '0;
            if (a < NSRC) begin
                st_d.rdata[PRIO_W-1:0] = st_q.prio[a];
                st_d.rdata[TRIG_BIT]   = st_q.trig[a];
            end else if (a < CBASE) begin
                st_d.rdata = st_q.vec[a-NSRC];
            end else begin
                case (a - CBASE)
                    OFS_ACK:  st_d.rdata = eligible ? st_q.vec[win_idx] : st_q.spur;
                    OFS_SPUR: st_d.rdata = st_q.spur;
                    OFS_MASK: st_d.rdata[NSRC-1:0] = st_q.en;
                    OFS_DBG:  st_d.rdata[0] = st_q.dbg;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // input assumption: one access per cycle
    p_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == CBASE + OFS_DIS) |=> ((st_q.en & $past(wdata[NSRC-1:0])) == '0));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == CBASE + OFS_CLR) |=> ((st_q.latch & $past(wdata[NSRC-1:0])) == '0));
    p_ack_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.trig[win_idx]) |=> !st_q.latch[$past(win_idx)]);
    p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eligible) |=> (rdata == $past(st_q.spur)));
    p_nest_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !stk_empty) |-> (win_prio > stk_top));
endmodule

// File: tb/vpic_test.sv
`timescale 1ns/1ps
module vpic_test;
    localparam int NSRC = 32;
    localparam int DW   = 32;
    localparam int AW   = 7;
    localparam int A_ACK = 64, A_SPUR = 65, A_EOI = 66, A_EN = 67,
                   A_DIS = 68, A_CLR = 69, A_MASK = 70, A_DBG = 71;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_n = '1;
    logic [AW-1:0]   addr = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq_n;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          saw_rd = 1'b0;

    always #2.5 clk = ~clk;

    vpic uut (.clk(clk), .rst_n(rst_n), .src_n(src_n), .addr(addr), .wr_en(wr_en),
              .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result against the scoreboard
    always @(posedge clk) saw_rd <= rd_en;
    always @(negedge clk) begin
        if (saw_rd && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rdata, e, t);
        end
    end

    task automatic wr_reg(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(input int a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk);
        src_n[i] = v;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        check({31'b0, irq_n}, {31'b0, e}, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq(1'b1, "R1 reset irq");
        rd_exp(A_MASK, 32'h0, "R1 reset mask");
        rd_exp(A_ACK, 32'h0, "R1 reset spurious");

        wr_reg(A_SPUR, 32'hDEAD_BEEF);
        rd_exp(A_SPUR, 32'hDEAD_BEEF, "R10 spurious readback");
        wr_reg(A_DBG, 32'h1);
        rd_exp(A_DBG, 32'h1, "R11 debug readback");

        for (int i = 0; i < NSRC; i++) wr_reg(NSRC + i, 32'h1000 + i);
        wr_reg(1, 32'h02);
        wr_reg(3, 32'h02);
        wr_reg(5, 32'h25);
        wr_reg(9, 32'h05);
        wr_reg(20, 32'h07);
        rd_exp(5, 32'h25, "R5 mode readback");
        wr_reg(A_EN, 32'h0010_022A);
        rd_exp(A_MASK, 32'h0010_022A, "R2 enable mask");
        wr_reg(A_DIS, 32'h2);
        rd_exp(A_MASK, 32'h0010_0228, "R2 disable mask");
        set_src(1, 1'b0);
        chk_irq(1'b1, "R2 disabled input ignored");

        set_src(3, 1'b0);
        chk_irq(1'b0, "R3 level asserts");
        set_src(3, 1'b1);
        chk_irq(1'b1, "R3 level not latched");

        set_src(5, 1'b0);
        set_src(5, 1'b1);
        chk_irq(1'b0, "R4 edge captured");
        wr_reg(A_CLR, 32'h20);
        chk_irq(1'b1, "R4 edge cleared");

        set_src(3, 1'b0);
        set_src(9, 1'b0);
        rd_exp(A_ACK, 32'h1009, "R5 R6 highest priority vector");
        chk_irq(1'b1, "R7 lower level masked by nesting");
        set_src(20, 1'b0);
        chk_irq(1'b0, "R7 higher level preempts");
        rd_exp(A_ACK, 32'h1014, "R6 nested vector");
        chk_irq(1'b1, "R7 after nested ack");
        rd_exp(A_ACK, 32'hDEAD_BEEF, "R10 spurious while nested");
        set_src(20, 1'b1);
        wr_reg(A_EOI, 32'h0);
        chk_irq(1'b1, "R8 one pop leaves level 5");
        wr_reg(A_EOI, 32'h0);
        chk_irq(1'b0, "R8 empty stack reopens");
        rd_exp(A_ACK, 32'h1009, "R6 re-ack level source");
        wr_reg(A_EOI, 32'h0);
        set_src(5, 1'b0);
        rd_exp(A_ACK, 32'h1005, "R5 tie lowest index");
        wr_reg(A_EOI, 32'h0);
        rd_exp(A_ACK, 32'h1009, "R6 ack discarded edge");
        wr_reg(A_EOI, 32'h0);
        set_src(3, 1'b1); set_src(9, 1'b1); set_src(5, 1'b1); set_src(1, 1'b1);
        chk_irq(1'b1, "R3 all released");

        wr_reg(A_EOI, 32'h0);
        wr_reg(A_EOI, 32'h0);
        set_src(3, 1'b0);
        rd_exp(A_ACK, 32'h1003, "R6 ack after empty pops");
        chk_irq(1'b1, "R8 empty pops left no underflow");
        wr_reg(A_EOI, 32'h0);
        chk_irq(1'b0, "R8 single pop empties");
        wr_reg(A_EOI, 32'h0);
        set_src(3, 1'b1);

        wr_reg(A_DIS, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr_reg(10 + k, DW'(k));
        wr_reg(A_EN, 32'h0003_FC00);
        rd_exp(A_MASK, 32'h0003_FC00, "R2 mask for depth test");
        for (int k = 0; k < 8; k++) begin
            set_src(10 + k, 1'b0);
            rd_exp(A_ACK, 32'h100A + k, "R9 nesting push");
        end
        chk_irq(1'b1, "R9 full stack");
        rd_exp(A_ACK, 32'hDEAD_BEEF, "R10 spurious at full depth");
        wr_reg(A_EOI, 32'h0);
        chk_irq(1'b0, "R8 pop exposes level 7");
        for (int k = 1; k < 8; k++) set_src(10 + k, 1'b1);
        for (int k = 0; k < 6; k++) wr_reg(A_EOI, 32'h0);
        chk_irq(1'b1, "R9 seven pops not enough");
        wr_reg(A_EOI, 32'h0);
        chk_irq(1'b0, "R9 eighth pop empties");
        rd_exp(A_DBG, 32'h1, "R11 debug unchanged");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule